// File: doc/BRIEF.md
# Interrupt Remap Entry Fetch Unit

This unit sits behind the device-table lookup of an I/O translation block. For each incoming message-signalled interrupt it receives the MSI address, the MSI data and the requester ID. It also receives the third 64-bit word and the domain ID of the device entry that the requester already fetched. It decides whether the interrupt goes through the remapping table at all. It checks the table-length code and bounds the entry index by it. It then forms the physical address of the 32-bit remapping entry and fetches that entry with one 4-byte read on a valid/ready memory port.

Each request ends with a single-cycle completion pulse that carries a status code and, on success, the fetched entry. When a check fails, the unit also emits an event record in the same cycle as the completion. The record says which class of fault occurred and carries the requester, the domain and the original MSI address. Only one request is in flight at a time: the input stays not-ready from acceptance until completion.

Top module: `intr_remap_fetch`

## Requirements
- R1: When the interrupt-control field (device word bits 61:60) is not 2'b10, the request completes with status 4 (bypass). It performs no memory read and raises no event.
- R2: When remapping is selected and the table-length code L (device word bits 4:1) is 12 or larger, the request completes with status 1 (remap failed). It raises an event of class 1 (illegal device entry) and performs no memory read.
- R3: The entry index is MSI data bits 10:0, and the higher data bits are ignored. With a legal L and an index of 2^L or more, the request completes with status 2 (translation failed). It raises an event of class 2 (page fault) with the entry-address-invalid flag set and the present, reserved-bit and permission flags clear, and performs no memory read.
- R4: Otherwise exactly one read is issued, at the address formed from device word bits 51:7 with seven zero bits below, plus the index times 4. That address is 4-byte aligned.
- R5: Every event carries the requester ID, the domain ID and the MSI address of the request that caused it. An event appears only together with a completion of status 1 or 2.
- R6: An error response to the read completes with status 3 (internal error) and an entry of zero, and raises no event.
- R7: A good response completes with status 0 (success), and the entry equals the response data.
- R8: Input ready is low from acceptance until completion. A memory request holds its valid and address steady until it is accepted.
- R9: After reset, completion, event and memory request are low and input ready is high. Completion is a one-cycle pulse. A request that needs no read completes on the second clock edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt lookup request offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_msi_addr | input | 64 | Address of the incoming interrupt message |
| req_msi_data | input | 32 | Data of the incoming interrupt message |
| req_dev_id | input | 16 | Requester ID |
| req_dom_id | input | 16 | Domain ID from the device entry |
| req_dte_word | input | 64 | Third 64-bit word of the device entry |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 4-byte read |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Unit waiting for the response |
| mem_rsp_err | input | 1 | Read response carries an error |
| mem_rsp_data | input | 32 | Read response data |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 3 | 0 ok, 1 remap failed, 2 translation failed, 3 internal error, 4 bypass |
| done_entry | output | 32 | Fetched remapping entry |
| evt_valid | output | 1 | Event record valid |
| evt_class | output | 2 | 1 illegal device entry, 2 page fault |
| evt_addr_invalid | output | 1 | Page-fault subtype: entry address invalid |
| evt_present | output | 1 | Page-fault present flag |
| evt_rsvd_nz | output | 1 | Reserved-bit flag |
| evt_perm_denied | output | 1 | Permission-denied flag |
| evt_dev_id | output | 16 | Requester ID of the faulting request |
| evt_dom_id | output | 16 | Domain ID of the faulting request |
| evt_msi_addr | output | 64 | MSI address of the faulting request |

## Verification
Each interrupt-control setting other than remap is tried. This separates the bypass path from the fault paths. Length codes 12 and 15 are placed against legal codes 0, 5 and 11, with indices on both sides of each bound (0/1, 31/32, and 2047 at the top). This exposes off-by-one and wrong-comparison errors and shows that data bits above 10 take no part. Device words with non-zero bits below bit 7 and above bit 51 show that the address uses only the base field. Request stalls, response latencies and an error response separate the success, internal-error and handshake-hold behaviour.

// File: rtl/irf_pkg.sv
package irf_pkg;

    typedef enum logic [2:0] {
        ST_OK         = 3'd0,
        ST_REMAP_FAIL = 3'd1,
        ST_XLATE_FAIL = 3'd2,
        ST_INT_ERR    = 3'd3,
        ST_BYPASS     = 3'd4
    } irf_status_e;

    typedef enum logic [1:0] {
        EV_NONE          = 2'd0,
        EV_ILLEGAL_ENTRY = 2'd1,
        EV_PAGE_FAULT    = 2'd2
    } irf_evt_class_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CHECK,
        S_REQ,
        S_WAIT
    } irf_state_e;

    typedef enum logic [1:0] {
        DEC_BYPASS,
        DEC_BAD_LEN,
        DEC_OUT_OF_RANGE,
        DEC_FETCH
    } irf_verdict_e;

    localparam logic [1:0] INTCTL_REMAP = 2'b10;

endpackage

// File: rtl/irf_field_decode.sv
module irf_field_decode #(
    parameter int DTE_W       = 64,
    parameter int DATA_W      = 32,
    parameter int PA_W        = 52,
    parameter int IDX_W       = 11,
    parameter int ENTRY_SHIFT = 2,
    parameter int LEN_W       = 4,
    parameter int LEN_LIMIT   = 12,
    parameter int BASE_LSB    = 7,
    parameter int CTL_LSB     = 60
) (
    input  logic [DTE_W-1:0]     dte_word,
    input  logic [DATA_W-1:0]    msi_data,
    output irf_pkg::irf_verdict_e verdict,
    output logic [PA_W-1:0]      entry_addr
);
    import irf_pkg::*;

    localparam int OFF_W = IDX_W + ENTRY_SHIFT;

    logic [1:0]       intctl;
    logic [LEN_W-1:0] len_code;
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] byte_off;
    logic [OFF_W:0]   byte_limit;
    logic [PA_W-1:0]  base;
    logic             unused_bits;

    assign intctl     = dte_word[CTL_LSB +: 2];
    assign len_code   = dte_word[1 +: LEN_W];
    assign idx        = msi_data[IDX_W-1:0];
    assign byte_off   = {idx, {ENTRY_SHIFT{1'b0}}};
    assign byte_limit = ({{OFF_W{1'b0}}, 1'b1} << len_code) << ENTRY_SHIFT;
    assign base       = {dte_word[PA_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    assign entry_addr = base + PA_W'(byte_off);

    assign unused_bits = ^{dte_word[0], dte_word[BASE_LSB-1:LEN_W+1],
                           dte_word[CTL_LSB-1:PA_W], dte_word[DTE_W-1:CTL_LSB+2],
                           msi_data[DATA_W-1:IDX_W]};

    always_comb begin
        if (intctl != INTCTL_REMAP) begin
            verdict = DEC_BYPASS;
        end else if (32'(len_code) >= LEN_LIMIT) begin
            verdict = DEC_BAD_LEN;
        end else if ({1'b0, byte_off} >= byte_limit) begin
            verdict = DEC_OUT_OF_RANGE;
        end else begin
            verdict = DEC_FETCH;
        end
    end

endmodule

// File: rtl/irf_event_pack.sv
module irf_event_pack (
    input  logic                    fire,
    input  irf_pkg::irf_evt_class_e cls,
    output logic                    evt_valid,
    output logic [1:0]              evt_class,
    output logic                    evt_addr_invalid,
    output logic                    evt_present,
    output logic                    evt_rsvd_nz,
    output logic                    evt_perm_denied
);
    import irf_pkg::*;

    always_comb begin
        evt_valid        = fire;
        evt_class        = fire ? cls : EV_NONE;
        evt_addr_invalid = fire && (cls == EV_PAGE_FAULT);
        evt_present      = 1'b0;
        evt_rsvd_nz      = 1'b0;
        evt_perm_denied  = 1'b0;
    end

endmodule

// File: rtl/intr_remap_fetch.sv
module intr_remap_fetch #(
    parameter int MSI_AW    = 64,
    parameter int DATA_W    = 32,
    parameter int DEV_W     = 16,
    parameter int DOM_W     = 16,
    parameter int DTE_W     = 64,
    parameter int PA_W      = 52,
    parameter int IDX_W     = 11,
    parameter int ENTRY_W   = 32,
    parameter int LEN_LIMIT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [MSI_AW-1:0] req_msi_addr,
    input  logic [DATA_W-1:0] req_msi_data,
    input  logic [DEV_W-1:0]  req_dev_id,
    input  logic [DOM_W-1:0]  req_dom_id,
    input  logic [DTE_W-1:0]  req_dte_word,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic              mem_rsp_err,
    input  logic [ENTRY_W-1:0] mem_rsp_data,
    output logic              done,
    output logic [2:0]        done_status,
    output logic [ENTRY_W-1:0] done_entry,
    output logic              evt_valid,
    output logic [1:0]        evt_class,
    output logic              evt_addr_invalid,
    output logic              evt_present,
    output logic              evt_rsvd_nz,
    output logic              evt_perm_denied,
    output logic [DEV_W-1:0]  evt_dev_id,
    output logic [DOM_W-1:0]  evt_dom_id,
    output logic [MSI_AW-1:0] evt_msi_addr
);
    import irf_pkg::*;

    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);

    typedef struct packed {
        irf_state_e        st;
        logic [MSI_AW-1:0] msi_addr;
        logic [DATA_W-1:0] msi_data;
        logic [DEV_W-1:0]  dev_id;
        logic [DOM_W-1:0]  dom_id;
        logic [DTE_W-1:0]  dte_word;
        logic [PA_W-1:0]   rd_addr;
        logic              done;
        irf_status_e       status;
        logic [ENTRY_W-1:0] entry;
        logic              evt_fire;
        irf_evt_class_e    evt_cls;
    } regs_t;

    regs_t        r_q, r_d;
    irf_verdict_e verdict;
    logic [PA_W-1:0] entry_addr;

    irf_field_decode #(
        .DTE_W(DTE_W), .DATA_W(DATA_W), .PA_W(PA_W), .IDX_W(IDX_W),
        .ENTRY_SHIFT(ENTRY_SHIFT), .LEN_LIMIT(LEN_LIMIT)
    ) u_decode (
        .dte_word   (r_q.dte_word),
        .msi_data   (r_q.msi_data),
        .verdict    (verdict),
        .entry_addr (entry_addr)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done     = 1'b0;
        r_d.evt_fire = 1'b0;
        r_d.evt_cls  = EV_NONE;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.msi_addr = req_msi_addr;
                    r_d.msi_data = req_msi_data;
                    r_d.dev_id   = req_dev_id;
                    r_d.dom_id   = req_dom_id;
                    r_d.dte_word = req_dte_word;
                    r_d.st       = S_CHECK;
                end
            end
            S_CHECK: begin
                unique case (verdict)
                    DEC_BYPASS: begin
                        r_d.done   = 1'b1;
                        r_d.status = ST_BYPASS;
                        r_d.entry  = '0;
                        r_d.st     = S_IDLE;
                    end
                    DEC_BAD_LEN: begin
                        r_d.done     = 1'b1;
                        r_d.status   = ST_REMAP_FAIL;
                        r_d.entry    = '0;
                        r_d.evt_fire = 1'b1;
                        r_d.evt_cls  = EV_ILLEGAL_ENTRY;
                        r_d.st       = S_IDLE;
                    end
                    DEC_OUT_OF_RANGE: begin
                        r_d.done     = 1'b1;
                        r_d.status   = ST_XLATE_FAIL;
                        r_d.entry    = '0;
                        r_d.evt_fire = 1'b1;
                        r_d.evt_cls  = EV_PAGE_FAULT;
                        r_d.st       = S_IDLE;
                    end
                    default: begin
                        r_d.rd_addr = entry_addr;
                        r_d.st      = S_REQ;
                    end
                endcase
            end
            S_REQ: begin
                if (mem_req_ready) begin
                    r_d.st = S_WAIT;
                end
            end
            default: begin
                if (mem_rsp_valid) begin
                    r_d.done   = 1'b1;
                    r_d.status = mem_rsp_err ? ST_INT_ERR : ST_OK;
                    r_d.entry  = mem_rsp_err ? '0 : mem_rsp_data;
                    r_d.st     = S_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.status <= ST_OK;
            r_q.evt_cls <= EV_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready     = (r_q.st == S_IDLE);
    assign mem_req_valid = (r_q.st == S_REQ);
    assign mem_req_addr  = r_q.rd_addr;
    assign mem_rsp_ready = (r_q.st == S_WAIT);
    assign done          = r_q.done;
    assign done_status   = r_q.status;
    assign done_entry    = r_q.entry;
    assign evt_dev_id    = r_q.dev_id;
    assign evt_dom_id    = r_q.dom_id;
    assign evt_msi_addr  = r_q.msi_addr;

    irf_event_pack u_evt (
        .fire             (r_q.evt_fire),
        .cls              (r_q.evt_cls),
        .evt_valid        (evt_valid),
        .evt_class        (evt_class),
        .evt_addr_invalid (evt_addr_invalid),
        .evt_present      (evt_present),
        .evt_rsvd_nz      (evt_rsvd_nz),
        .evt_perm_denied  (evt_perm_denied)
    );

endmodule

// File: rtl/irf_checker.sv
module irf_checker #(
    parameter int PA_W = 52
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [PA_W-1:0] mem_req_addr,
    input logic            done,
    input logic [2:0]      done_status,
    input logic            evt_valid
);

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R4

    AST_EVT_WITH_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (done && (done_status == 3'd1 || done_status == 3'd2))); // R5

    AST_ERR_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_status == 3'd3) |-> !evt_valid); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

endmodule

bind intr_remap_fetch irf_checker #(.PA_W(PA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .done_status   (done_status),
    .evt_valid     (evt_valid)
);

// File: tb/intr_remap_fetch_test.sv
module intr_remap_fetch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_msi_addr = '0;
    logic [31:0] req_msi_data = '0;
    logic [15:0] req_dev_id = '0;
    logic [15:0] req_dom_id = '0;
    logic [63:0] req_dte_word = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_ready;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done;
    logic [2:0]  done_status;
    logic [31:0] done_entry;
    logic        evt_valid;
    logic [1:0]  evt_class;
    logic        evt_addr_invalid, evt_present, evt_rsvd_nz, evt_perm_denied;
    logic [15:0] evt_dev_id, evt_dom_id;
    logic [63:0] evt_msi_addr;

    always #4 clk = ~clk;

    intr_remap_fetch uut (.*);

    typedef struct {
        logic [2:0]  st;
        logic [31:0] entry;
        logic        ev;
        logic [1:0]  cls;
        int          reads;
        logic [51:0] addr;
        logic [15:0] dev;
        logic [15:0] dom;
        logic [63:0] maddr;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          total = 0;
    int          bad = 0;
    int          nreads = 0;
    int          exp_reads = 0;
    logic [51:0] last_addr = '0;
    logic        cur_err = 1'b0;
    int          cur_stall = 0;
    int          cur_lat = 0;

    function automatic logic [31:0] mem_word(input logic [51:0] a);
        return {a[31:2], 2'b01} ^ 32'h5A00_0000;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (cur_stall) @(negedge clk);
                mem_req_ready = 1'b1;
                last_addr = mem_req_addr;
                nreads++;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (cur_lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = cur_err;
                mem_rsp_data  = mem_word(last_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    // monitor
    initial begin
        logic prev_done;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (done && prev_done) chk("R9", "done longer than one cycle", 1, 0);
                if (evt_valid && !done) chk("R5", "event without completion", 1, 0);
                if (done) begin
                    if (sb.size() == 0) begin
                        chk("R9", "unexpected completion", 1, 0);
                    end else begin
                        item_t it;
                        it = sb.pop_front();
                        case (it.st)
                            3'd0: chk("R7", {it.tag, " status"}, done_status, it.st);
                            3'd1: chk("R2", {it.tag, " status"}, done_status, it.st);
                            3'd2: chk("R3", {it.tag, " status"}, done_status, it.st);
                            3'd3: chk("R6", {it.tag, " status"}, done_status, it.st);
                            default: chk("R1", {it.tag, " status"}, done_status, it.st);
                        endcase
                        if (it.st == 3'd0) chk("R7", {it.tag, " entry"}, done_entry, it.entry);
                        if (it.st == 3'd3) chk("R6", {it.tag, " entry zero"}, done_entry, 0);
                        chk(it.st == 3'd3 ? "R6" : "R5", {it.tag, " event valid"}, evt_valid, it.ev);
                        chk("R4", {it.tag, " read count"}, nreads, it.reads);
                        if (it.st == 3'd0 || it.st == 3'd3)
                            chk("R4", {it.tag, " read address"}, last_addr, it.addr);
                        if (it.ev) begin
                            chk(it.cls == 2'd1 ? "R2" : "R3", {it.tag, " event class"}, evt_class, it.cls);
                            chk("R3", {it.tag, " event flags"},
                                {evt_addr_invalid, evt_present, evt_rsvd_nz, evt_perm_denied},
                                {(it.cls == 2'd2), 3'b000});
                            chk("R5", {it.tag, " event ids"}, {evt_dev_id, evt_dom_id}, {it.dev, it.dom});
                            chk("R5", {it.tag, " event msi addr"}, evt_msi_addr, it.maddr);
                        end
                    end
                end
                prev_done = done;
            end
        end
    end

    task automatic send(input logic [1:0] ctl, input logic [3:0] len, input logic [51:0] base,
                        input logic [31:0] data, input logic err, input int stall, input int lat,
                        input string tag);
        item_t       it;
        logic [63:0] w;
        logic [10:0] idx;
        logic        needs_read;
        w = {2'b11, ctl, 8'hA5, base[51:7], 2'b11, len, 1'b1};
        idx = data[10:0];
        it.tag   = tag;
        it.dev   = 16'h1000 + 16'(total);
        it.dom   = 16'h2200 ^ 16'(total);
        it.maddr = 64'hFEE0_0000_0000_0000 | 64'(total);
        it.ev    = 1'b0;
        it.cls   = 2'd0;
        it.entry = '0;
        it.addr  = {base[51:7], 7'b0} + 52'(idx) * 4;
        needs_read = 1'b0;
        if (ctl != 2'b10) begin
            it.st = 3'd4;
        end else if (len >= 4'd12) begin
            it.st = 3'd1; it.ev = 1'b1; it.cls = 2'd1;
        end else if (32'(idx) >= (32'd1 << len)) begin
            it.st = 3'd2; it.ev = 1'b1; it.cls = 2'd2;
        end else begin
            needs_read = 1'b1;
            exp_reads++;
            it.st = err ? 3'd3 : 3'd0;
            it.entry = err ? 32'd0 : mem_word(it.addr);
        end
        it.reads = exp_reads;
        cur_err = err; cur_stall = stall; cur_lat = lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sb.push_back(it);
        req_msi_addr = it.maddr;
        req_msi_data = data;
        req_dev_id   = it.dev;
        req_dom_id   = it.dom;
        req_dte_word = w;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid    = 1'b0;
        req_msi_data = ~data;
        req_dte_word = ~w;
        chk("R8", {tag, " ready low after accept"}, req_ready, 0);
        @(negedge clk);
        if (!needs_read) chk("R9", {tag, " completion latency"}, done, 1);
        while (sb.size() > 0) @(negedge clk);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R9", "reset done", done, 0);
        chk("R9", "reset event", evt_valid, 0);
        chk("R9", "reset mem req", mem_req_valid, 0);
        chk("R9", "reset ready", req_ready, 1);

        send(2'b00, 4'd3, 52'h0_1234_5678_9A80, 32'h0000_0001, 1'b0, 0, 0, "R1 ctl00");
        send(2'b01, 4'd3, 52'h0_1234_5678_9A80, 32'h0000_0001, 1'b0, 0, 0, "R1 ctl01");
        send(2'b11, 4'd3, 52'h0_1234_5678_9A80, 32'h0000_0001, 1'b0, 0, 0, "R1 ctl11");
        send(2'b10, 4'd12, 52'h0_0000_0000_1000, 32'h0000_0000, 1'b0, 0, 0, "R2 len12");
        send(2'b10, 4'd15, 52'h0_0000_0000_1000, 32'h0000_0000, 1'b0, 0, 0, "R2 len15");
        send(2'b10, 4'd0, 52'h0_0000_0000_1000, 32'h0000_0000, 1'b0, 0, 0, "R4 len0 idx0");
        send(2'b10, 4'd0, 52'h0_0000_0000_1000, 32'h0000_0001, 1'b0, 0, 0, "R3 len0 idx1");
        send(2'b10, 4'd5, 52'h0_ABCD_0000_0080, 32'hABCD_F81F, 1'b0, 1, 2, "R3 len5 idx31 high data");
        send(2'b10, 4'd5, 52'h0_ABCD_0000_0080, 32'hABCD_F820, 1'b0, 0, 0, "R3 len5 idx32");
        send(2'b10, 4'd11, 52'hF_FFFF_FFFF_FF80, 32'h0000_07FF, 1'b0, 3, 0, "R4 len11 idx2047");
        send(2'b10, 4'd11, 52'h8_0000_0004_0000, 32'h0000_0123, 1'b0, 0, 4, "R7 latency");
        send(2'b10, 4'd7, 52'h0_0000_0010_0000, 32'h0000_0042, 1'b1, 2, 1, "R6 error rsp");
        send(2'b10, 4'd7, 52'h0_0000_0010_0000, 32'h0000_0043, 1'b0, 0, 0, "R7 after error");

        repeat (4) @(negedge clk);
        chk("R4", "total reads", nreads, exp_reads);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule